// File: doc/BRIEF.md
# Synchronous Card Bit-Count Serial Engine

This block moves serial data between two small byte queues and the bidirectional data line of a card that runs with a synchronous clock. A separate clock generator produces the card clock. It sends this block single-cycle strobes for each rising and falling card-clock edge. It also sends a level that is high while the clock is held stopped in the high state. The engine drives outgoing bits, least significant first, on falling edges. It samples incoming bits on rising edges. The data line is open-drain: the block only ever pulls it low.

Software sets the length of a transfer by loading a bit-length count. Each falling edge advances the count. When the count reaches the loaded value, transfers stop, an interrupt flag is raised and the count freezes until the next load. A loaded length of zero means no transfer at all. While the engine is idle in this way, software can take direct control of the line if direct mode is on.

The receive side can collect 9-bit words, with the extra bit on its own output. Two edge cases are handled. Changing direction restarts the bit position. Two back-to-back reads of the transmit queue empty it.

Top module: `sync_card_engine`

## Requirements
- R1: After reset, `irq`, `io_oe`, `io_sampled` and `tx_full` are 0 and `rx_empty` is 1.
- R2: With `dir_tx`=1 and a length active, each falling strobe drives the next bit of the head transmit byte, starting at bit 0. Bytes go out in push order. `io_oe` is 1 while the driven bit is 0 and 0 while it is 1.
- R3: A load of N (1 to 255) lets exactly N falling strobes through. The N-th one sets the interrupt flag. After that, further falling strobes change neither the line nor the flag, until the next load.
- R4: `irq` equals the interrupt flag ANDed with `irq_en`. The flag stays set, even while masked, until an `irq_clr` pulse.
- R5: A loaded length of 0 moves no bits in either direction and never sets the flag.
- R6: Direct mode applies when `direct_en`=1 and the length is either 0 or complete. In direct mode, `io_oe` = `dir_tx` AND NOT `sw_data`. While a length is still counting, `sw_data` has no effect, and a freshly loaded length leaves the line released.
- R7: `io_sampled` takes the level of `io_in` on every rising strobe, whatever the mode, and holds it between strobes.
- R8: With `dir_tx`=0 and `mode9`=0, rising strobes assemble bytes LSB first. A byte becomes readable (`rx_empty`=0, value on `rx_rdata`) on the cycle after its 8th rising strobe, and not earlier.
- R9: With `mode9`=1, a word is 9 bits long. Bits 0 to 7 appear on `rx_rdata` and bit 8 on `rx_bit9`. The word is readable only after its 9th rising strobe.
- R10: Suppose `clk_parked_hi` was high after a load and before the first falling strobe. Then that first falling strobe counts toward the length but does not shift or drive any bit.
- R11: Any change of `dir_tx` resets the bit position to 0, so a partly assembled word is discarded.
- R12: Two `tx_rd` pulses on consecutive cycles, with no push between them, empty the transmit queue. The next pushed byte is then the first one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_rise | input | 1 | Card clock rising-edge strobe |
| clk_fall | input | 1 | Card clock falling-edge strobe |
| clk_parked_hi | input | 1 | High while the card clock is held stopped high |
| tx_push | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| tx_rd | input | 1 | Software read access to the transmit queue |
| rx_pop | input | 1 | Remove the head receive word |
| rx_rdata | output | 8 | Head receive word, bits 7:0 |
| rx_bit9 | output | 1 | Head receive word, bit 8 |
| rx_empty | output | 1 | Receive queue empty (data available when 0) |
| len_load | input | 1 | Load `len_value` and restart counting |
| len_value | input | LENW | Number of card-clock cycles to transfer |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| mode9 | input | 1 | 9-bit receive words |
| direct_en | input | 1 | Allow software control of the line when idle |
| sw_data | input | 1 | Software line level for direct mode |
| irq_en | input | 1 | Interrupt mask enable |
| irq_clr | input | 1 | Clear the interrupt flag |
| io_in | input | 1 | Card data line level |
| io_oe | output | 1 | Pull the card data line low |
| io_sampled | output | 1 | Line level at the last rising strobe |
| irq | output | 1 | Length-complete interrupt |

## Verification
A bit position that drifts inside the engine is visible at the ports almost at once. On transmit, `io_oe` shows the wrong level on the very next falling strobe. On receive, a word is released one strobe early or late, or `rx_rdata` holds a rotated value, at the end of the current word. A miscounting length register moves the `irq` assertion off the N-th falling strobe. It also makes the line move after completion, on the cycle after the extra strobe. A transmit queue pointer that went unflushed replays a stale byte on the first bit of the next transfer.

// File: rtl/sync_card_engine.sv
module sync_card_engine #(
  parameter int DEPTH = 4,
  parameter int LENW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_rise,
  input  logic            clk_fall,
  input  logic            clk_parked_hi,
  input  logic            tx_push,
  input  logic [7:0]      tx_wdata,
  output logic            tx_full,
  input  logic            tx_rd,
  input  logic            rx_pop,
  output logic [7:0]      rx_rdata,
  output logic            rx_bit9,
  output logic            rx_empty,
  input  logic            len_load,
  input  logic [LENW-1:0] len_value,
  input  logic            dir_tx,
  input  logic            mode9,
  input  logic            direct_en,
  input  logic            sw_data,
  input  logic            irq_en,
  input  logic            irq_clr,
  input  logic            io_in,
  output logic            io_oe,
  output logic            io_sampled,
  output logic            irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [7:0]      txm [DEPTH];
  logic [8:0]      rxm [DEPTH];
  logic [AW-1:0]   twp, trp, rwp, rrp;
  logic [AW:0]     tcnt, rcnt;
  logic [LENW-1:0] len_max, len_cnt, len_nxt;
  logic            done, fresh, hi_stop, flag, dir_q, rd_armed, tx_bit, samp;
  logic [3:0]      bptr;
  logic [8:0]      shreg, rx_word;

  wire active   = (len_max != '0) && !done;
  wire fall_ev  = clk_fall && active;
  wire skip     = fresh && hi_stop;
  wire dir_chg  = dir_tx != dir_q;
  wire tx_has   = tcnt != '0;
  wire tx_go    = fall_ev && !skip && dir_tx && !dir_chg;
  wire tx_pop_i = tx_go && tx_has && bptr == 4'd7;
  wire rx_go    = clk_rise && active && !dir_tx && !dir_chg && !len_load;
  wire [3:0] last = mode9 ? 4'd8 : 4'd7;
  wire rx_wdone = rx_go && bptr == last;
  wire rx_push  = rx_wdone && rcnt != FULL;
  wire rx_pop_i = rx_pop && !rx_empty;
  wire flush    = tx_rd && rd_armed;
  wire push_ok  = tx_push && !tx_full && !flush;
  wire direct   = direct_en && (len_max == '0 || done);

  assign len_nxt    = len_cnt + 1'b1;
  assign tx_full    = tcnt == FULL;
  assign rx_empty   = rcnt == '0;
  assign rx_rdata   = rxm[rrp][7:0];
  assign rx_bit9    = rxm[rrp][8];
  assign io_oe      = dir_tx && !(direct ? sw_data : tx_bit);
  assign io_sampled = samp;
  assign irq        = flag && irq_en;

  always_comb begin
    rx_word = shreg;
    rx_word[bptr] = io_in;
    if (!mode9) rx_word[8] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push_ok) txm[twp] <= tx_wdata;
    if (rx_push) rxm[rwp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0; rd_armed <= 1'b0;
    end else if (flush) begin
      twp <= '0; trp <= '0; tcnt <= '0; rd_armed <= 1'b0;
    end else begin
      if (push_ok) twp <= twp + 1'b1;
      if (tx_pop_i) trp <= trp + 1'b1;
      tcnt <= tcnt + push_ok - tx_pop_i;
      if (tx_rd) rd_armed <= 1'b1;
      else if (tx_push) rd_armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (rx_push) rwp <= rwp + 1'b1;
      if (rx_pop_i) rrp <= rrp + 1'b1;
      rcnt <= rcnt + rx_push - rx_pop_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_max <= '0; len_cnt <= '0; done <= 1'b0; fresh <= 1'b0; flag <= 1'b0;
    end else begin
      if (len_load) begin
        len_max <= len_value; len_cnt <= '0; done <= 1'b0; fresh <= 1'b1;
      end else if (fall_ev) begin
        len_cnt <= len_nxt; fresh <= 1'b0;
        if (len_nxt == len_max) done <= 1'b1;
      end
      if (!len_load && fall_ev && len_nxt == len_max) flag <= 1'b1;
      else if (irq_clr) flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bptr <= '0; shreg <= '0; tx_bit <= 1'b1; dir_q <= 1'b0;
      hi_stop <= 1'b0; samp <= 1'b0;
    end else begin
      dir_q <= dir_tx;
      if (clk_parked_hi) hi_stop <= 1'b1;
      else if (clk_fall) hi_stop <= 1'b0;
      if (clk_rise) samp <= io_in;
      if (len_load) tx_bit <= 1'b1;
      else if (tx_go) tx_bit <= tx_has ? txm[trp][bptr[2:0]] : 1'b1;
      if (len_load || dir_chg) bptr <= '0;
      else if (tx_go && tx_has) bptr <= (bptr == 4'd7) ? 4'd0 : bptr + 1'b1;
      else if (rx_go) begin
        shreg <= rx_word;
        bptr  <= rx_wdone ? 4'd0 : bptr + 1'b1;
      end
    end
  end

  a_r12_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= FULL);
  a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= FULL);
  a_r3_done_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> len_cnt == len_max);
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !len_load) |=> $stable(len_cnt));
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n) irq |-> irq_en);
  a_r2_rx_release: assert property (@(posedge clk) disable iff (!rst_n) !dir_tx |-> !io_oe);
  a_r8_push_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rise |=> rcnt <= $past(rcnt));
  a_r8_bptr_range: assert property (@(posedge clk) disable iff (!rst_n) bptr <= 4'd8);
endmodule

// File: tb/sim_sync_card_engine.sv
module sim_sync_card_engine;
  logic clk = 0, rst_n = 0;
  logic clk_rise = 0, clk_fall = 0, clk_parked_hi = 0;
  logic tx_push = 0, tx_rd = 0, rx_pop = 0, len_load = 0;
  logic [7:0] tx_wdata = 0, len_value = 0;
  logic dir_tx = 0, mode9 = 0, direct_en = 0, sw_data = 0, irq_en = 0, irq_clr = 0, io_in = 0;
  logic tx_full, rx_bit9, rx_empty, io_oe, io_sampled, irq;
  logic [7:0] rx_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sync_card_engine u0 (.*);

  task automatic tick(); @(negedge clk); endtask
  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask
  task automatic fall(); clk_fall = 1; tick(); clk_fall = 0; tick(); endtask
  task automatic rise(); clk_rise = 1; tick(); clk_rise = 0; tick(); endtask
  task automatic push(input logic [7:0] b); tx_push = 1; tx_wdata = b; tick(); tx_push = 0; endtask
  task automatic load(input int n); len_load = 1; len_value = 8'(n); tick(); len_load = 0; tick(); endtask
  task automatic clr(); irq_clr = 1; tick(); irq_clr = 0; endtask
  task automatic pop(); rx_pop = 1; tick(); rx_pop = 0; tick(); endtask
  task automatic flush(); tx_rd = 1; tick(); tick(); tx_rd = 0; tick(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w16;
    logic [17:0] w18;
    repeat (3) tick();
    rst_n = 1; tick();
    // R1
    chk("R1 irq", irq, 0); chk("R1 oe", io_oe, 0); chk("R1 samp", io_sampled, 0);
    chk("R1 full", tx_full, 0); chk("R1 empty", rx_empty, 1);

    // R2 transmit two bytes, R3 completion
    irq_en = 1; dir_tx = 1; tick();
    push(8'hA5); push(8'h3C);
    w16 = 16'h3CA5;
    load(16);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R3 irq before last", irq, 0);
      fall();
      chk("R2 tx bit", io_oe, !w16[i]);
      rise();
    end
    chk("R3 irq at N", irq, 1);
    push(8'hFF);
    for (int i = 0; i < 3; i++) begin fall(); chk("R3 frozen line", io_oe, 1); end
    // R4
    irq_en = 0; tick(); chk("R4 masked", irq, 0);
    irq_en = 1; tick(); chk("R4 held", irq, 1);
    clr(); tick(); chk("R4 cleared", irq, 0);

    // R12 flush then length 1
    flush(); push(8'h02); load(1);
    fall(); chk("R12 first after flush", io_oe, 1); chk("R3 len1 irq", irq, 1);

    // R6 direct mode
    direct_en = 1; sw_data = 0; tick(); chk("R6 direct low", io_oe, 1);
    sw_data = 1; tick(); chk("R6 direct high", io_oe, 0);
    sw_data = 0; load(5); chk("R6 blocked while counting", io_oe, 0);
    load(0); chk("R6 direct len0", io_oe, 1);
    direct_en = 0; sw_data = 1; clr(); tick();

    // R5 length 0
    dir_tx = 0; io_in = 0; tick();
    for (int i = 0; i < 8; i++) begin rise(); fall(); end
    chk("R5 no rx", rx_empty, 1); chk("R5 no irq", irq, 0);

    // R7
    io_in = 1; rise(); chk("R7 sample 1", io_sampled, 1);
    io_in = 0; tick(); chk("R7 hold", io_sampled, 1);
    rise(); chk("R7 sample 0", io_sampled, 0);

    // R8 8-bit receive
    w16 = 16'h4B96; load(16);
    for (int i = 0; i < 16; i++) begin
      io_in = w16[i]; rise();
      if (i == 6) chk("R8 not early", rx_empty, 1);
      if (i == 7) begin chk("R8 avail", rx_empty, 0); chk("R8 byte0", rx_rdata, 8'h96); end
      fall();
    end
    pop(); chk("R8 byte1", rx_rdata, 8'h4B); pop(); chk("R8 drained", rx_empty, 1);

    // R9 9-bit receive
    mode9 = 1; w18 = {9'h05A, 9'h1A5}; load(18);
    for (int i = 0; i < 18; i++) begin
      io_in = w18[i]; rise();
      if (i == 7) chk("R9 not early", rx_empty, 1);
      if (i == 8) begin
        chk("R9 avail", rx_empty, 0); chk("R9 low", rx_rdata, 8'hA5); chk("R9 bit9", rx_bit9, 1);
      end
      fall();
    end
    pop(); chk("R9 low2", rx_rdata, 8'h5A); chk("R9 bit9 2", rx_bit9, 0); pop();
    mode9 = 0; clr();

    // R11 direction change
    load(16); io_in = 1;
    for (int i = 0; i < 3; i++) begin rise(); fall(); end
    dir_tx = 1; tick(); dir_tx = 0; tick(); tick();
    for (int i = 0; i < 8; i++) begin io_in = (8'h5A >> i) & 1; rise(); fall(); end
    chk("R11 avail", rx_empty, 0); chk("R11 realigned", rx_rdata, 8'h5A); pop();

    // R10 parked-high restart
    clr(); dir_tx = 1; tick(); flush(); push(8'h02); load(2);
    clk_parked_hi = 1; tick(); clk_parked_hi = 0; tick();
    fall(); chk("R10 skipped", io_oe, 0); chk("R10 counted no irq", irq, 0);
    fall(); chk("R10 bit0 next", io_oe, 1); chk("R10 irq", irq, 1);

    // R3 sweep over lengths
    dir_tx = 0; tick();
    for (int n = 1; n <= 12; n++) begin
      clr(); load(n);
      for (int k = 1; k < n; k++) fall();
      chk("R3 sweep before", irq, 0);
      fall(); chk("R3 sweep at N", irq, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule